// File: doc/BRIEF.md
# PSRAM Configuration Register Write Sequencer

This block sits between a host and a pseudo-static RAM and programs the memory's two configuration registers: the refresh configuration register and the bus configuration register. The host gives a register select, an 18-bit register value and a timing flag. On a one-cycle start pulse the sequencer puts the select into address bits 19:18 and the value into bits 17:0, then drives the chip enable, write enable, output enable, address valid, configuration enable and memory clock pins through a fixed command. In asynchronous timing the memory clock stays low. In synchronous timing one rising memory clock edge captures the address. The data pins play no part in this command.

The same start input can instead request a no-operation cycle, which selects the device and leaves every other strobe inactive. A register write waits while another agent holds the device selected, because the memory only accepts a configuration write while it is deselected. A no-operation cycle does not wait. A select code that names no register is rejected without touching the bus. A busy flag and a one-cycle done pulse report progress to the host.

Top module: `cfgwr_seq`

## Requirements
- R1: While reset is active and after its release, memCeN, memWeN, memOeN and memAdvN are high. memCre, memClk, memAddr, busy, done and selErr are all low.
- R2: During a register write, memAddr[19:18] equals regSel, where 00 is the refresh configuration register and 10 is the bus configuration register, and memAddr[17:0] equals regValue. memAddr is zero at all other times.
- R3: An asynchronous register write (syncMode=0, isNop=0) begins at the clock edge that samples startCmd. It lasts ASYNC_CYCLES cycles, with memCeN and memWeN low, memCre high, memOeN high and memClk low. memAdvN is low only in the first of these cycles.
- R4: A synchronous register write (syncMode=1, isNop=0) lasts three cycles with memCeN, memWeN and memAdvN low, memCre high and memOeN high. memClk is high only in the second cycle, so there is exactly one rising edge.
- R5: A no-operation cycle (isNop=1) drives memCeN low while memWeN, memAdvN and memOeN stay high, memCre stays low and memAddr is zero. In asynchronous timing it lasts ASYNC_CYCLES cycles with memClk low. In synchronous timing it lasts three cycles with memClk high in the second.
- R6: A register write started while devSelected is high holds busy high with all strobes inactive. Its command begins at the first clock edge that samples devSelected low. A no-operation cycle starts at once whatever devSelected is.
- R7: busy is high from the start edge through the last active cycle of the command. In the following cycle all strobes are inactive, busy is low and done is high for exactly one cycle. After that a new start is accepted.
- R8: A startCmd pulse during a command or during the done cycle is ignored and changes neither the running sequence nor the cycle after it.
- R9: A register write with regSel 01 or 11 raises done and selErr together for one cycle, one cycle after the start edge. busy stays low and no strobe or address bit becomes active.
- R10: The select and value are captured at the start edge. Changes on regSel, regValue, syncMode or isNop after that edge do not alter the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startCmd | input | 1 | One-cycle command request |
| isNop | input | 1 | 1 = no-operation cycle, 0 = configuration register write |
| syncMode | input | 1 | 1 = synchronous clock-edge timing, 0 = asynchronous timing |
| regSel | input | 2 | Target register code placed on the top two address bits |
| regValue | input | ADDR_W-2 | Value placed on the remaining address bits |
| devSelected | input | 1 | High while another agent keeps the memory selected |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low, always inactive here |
| memAdvN | output | 1 | Memory address valid, active low |
| memCre | output | 1 | Memory configuration register enable, active high |
| memClk | output | 1 | Memory clock |
| memAddr | output | ADDR_W | Memory address bus |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| selErr | output | 1 | One-cycle pulse with done for a rejected select code |

## Verification
The bench compares the full pin bundle cycle by cycle against the length and shape of each command type. A design that pulsed the address valid strobe in the wrong cycle, gave the clock two edges, or left the write enable active in a no-operation cycle would show up at once. It holds a register write behind a selected device and checks that the strobes stay quiet until the device is released. A design that ignored the wait would assert the configuration strobe on a busy bus. It also fires a second start, with different values, in the middle of a command and again in its done cycle. A design without an input latch or with a loose idle check would switch the address or start a spurious cycle. Rejected select codes are checked for a done and error pulse with no bus activity, which catches a design that decodes only one bit or issues the cycle anyway.

// File: rtl/cfgwr_pkg.sv
package cfgwr_pkg;

  // Per-cycle intent from the control FSM to the pin datapath (active-high).
  typedef struct packed {
    logic load;     // capture select and value this edge
    logic ce;       // select the device
    logic we;       // write strobe
    logic cre;      // configuration register access
    logic adv;      // address valid
    logic clkHi;    // memory clock high
    logic drvAddr;  // drive the captured address
    logic busy;
    logic done;
    logic err;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ASYNC,
    ST_SCLKLO,
    ST_SCLKHI,
    ST_SHOLD,
    ST_DONE
  } state_t;

endpackage

// File: rtl/cfgwr_ctrl.sv
module cfgwr_ctrl
  import cfgwr_pkg::*;
#(
  parameter int ASYNC_CYCLES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startCmd,
  input  logic    isNop,
  input  logic    syncMode,
  input  logic    selInvalid,
  input  logic    devSelected,
  output strobe_t strobe
);

  localparam int CNT_W = (ASYNC_CYCLES > 2) ? $clog2(ASYNC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ASYNC_CYCLES - 1);

  state_t           state, nextState;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             nopQ, syncQ;
  logic             effNop, load, errNext, active, firstAsync;

  always_comb begin
    nextState = state;
    cntNext   = cnt;
    load      = 1'b0;
    errNext   = 1'b0;
    effNop    = nopQ;
    unique case (state)
      ST_IDLE: begin
        effNop = isNop;
        if (startCmd) begin
          if (!isNop && selInvalid) begin
            nextState = ST_DONE;
            errNext   = 1'b1;
          end else begin
            load    = 1'b1;
            cntNext = '0;
            if (!isNop && devSelected) nextState = ST_WAIT;
            else nextState = syncMode ? ST_SCLKLO : ST_ASYNC;
          end
        end
      end
      ST_WAIT: begin
        if (!devSelected) begin
          nextState = syncQ ? ST_SCLKLO : ST_ASYNC;
          cntNext   = '0;
        end
      end
      ST_ASYNC: begin
        if (cnt == CNT_LAST) nextState = ST_DONE;
        else cntNext = cnt + 1'b1;
      end
      ST_SCLKLO: nextState = ST_SCLKHI;
      ST_SCLKHI: nextState = ST_SHOLD;
      ST_SHOLD:  nextState = ST_DONE;
      ST_DONE:   nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  // Strobes describe the state being entered; the datapath registers them.
  always_comb begin
    active     = (nextState == ST_ASYNC) || (nextState == ST_SCLKLO) ||
                 (nextState == ST_SCLKHI) || (nextState == ST_SHOLD);
    firstAsync = (nextState == ST_ASYNC) && (cntNext == '0);
    strobe.load    = load;
    strobe.ce      = active;
    strobe.we      = active && !effNop;
    strobe.cre     = active && !effNop;
    strobe.adv     = !effNop && (firstAsync || (active && nextState != ST_ASYNC));
    strobe.clkHi   = (nextState == ST_SCLKHI);
    strobe.drvAddr = active && !effNop;
    strobe.busy    = active || (nextState == ST_WAIT);
    strobe.done    = (nextState == ST_DONE);
    strobe.err     = errNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      nopQ  <= 1'b0;
      syncQ <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= cntNext;
      if (load) begin
        nopQ  <= isNop;
        syncQ <= syncMode;
      end
    end
  end

endmodule

// File: rtl/cfgwr_datapath.sv
module cfgwr_datapath
  import cfgwr_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int VAL_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [1:0]        regSel,
  input  logic [VAL_W-1:0]  regValue,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memAdvN,
  output logic              memCre,
  output logic              memClk,
  output logic [ADDR_W-1:0] memAddr,
  output logic              busy,
  output logic              done,
  output logic              selErr
);

  logic [ADDR_W-1:0] cmdAddr;
  logic [ADDR_W-1:0] newAddr;

  // Register code rides on the two top address bits, value below it.
  assign newAddr = {regSel, regValue};
  // Reads are never issued by this block.
  assign memOeN  = 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAddr <= '0;
      memCeN  <= 1'b1;
      memWeN  <= 1'b1;
      memAdvN <= 1'b1;
      memCre  <= 1'b0;
      memClk  <= 1'b0;
      memAddr <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      selErr  <= 1'b0;
    end else begin
      if (strobe.load) cmdAddr <= newAddr;
      memCeN  <= !strobe.ce;
      memWeN  <= !strobe.we;
      memAdvN <= !strobe.adv;
      memCre  <= strobe.cre;
      memClk  <= strobe.clkHi;
      memAddr <= strobe.drvAddr ? (strobe.load ? newAddr : cmdAddr) : '0;
      busy    <= strobe.busy;
      done    <= strobe.done;
      selErr  <= strobe.err;
    end
  end

endmodule

// File: rtl/cfgwr_seq.sv
module cfgwr_seq
  import cfgwr_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int ASYNC_CYCLES = 3,
  localparam int VAL_W       = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic              isNop,
  input  logic              syncMode,
  input  logic [1:0]        regSel,
  input  logic [VAL_W-1:0]  regValue,
  input  logic              devSelected,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memAdvN,
  output logic              memCre,
  output logic              memClk,
  output logic [ADDR_W-1:0] memAddr,
  output logic              busy,
  output logic              done,
  output logic              selErr
);

  if (ASYNC_CYCLES < 2) begin : g_badLen
    $error("ASYNC_CYCLES must be at least 2");
  end

  strobe_t strobe;
  logic    selInvalid;

  // Valid codes are 00 and 10; the odd codes name no register.
  assign selInvalid = regSel[0];

  cfgwr_ctrl #(.ASYNC_CYCLES(ASYNC_CYCLES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startCmd   (startCmd),
    .isNop      (isNop),
    .syncMode   (syncMode),
    .selInvalid (selInvalid),
    .devSelected(devSelected),
    .strobe     (strobe)
  );

  cfgwr_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regSel  (regSel),
    .regValue(regValue),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memAdvN (memAdvN),
    .memCre  (memCre),
    .memClk  (memClk),
    .memAddr (memAddr),
    .busy    (busy),
    .done    (done),
    .selErr  (selErr)
  );

endmodule

// File: rtl/cfgwr_seq_chk.sv
module cfgwr_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              devSelected,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memAdvN,
  input logic              memCre,
  input logic              memClk,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              done,
  input logic              selErr
);

  assert_cre_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    memCre |-> (!memCeN && !memWeN && memOeN));

  assert_clk_in_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    memClk |-> (!memCeN && busy));

  assert_edge_adv_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memClk) && memCre) |-> !memAdvN);

  assert_nop_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !memCre) |-> (memWeN && memAdvN && memOeN && memAddr == '0));

  assert_wait_deselect_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCre) |-> !$past(devSelected));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && memCeN && memWeN && memAdvN && !memCre));

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    selErr |-> done);

  assert_sel_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    memCre |-> !memAddr[ADDR_W-2]);

endmodule

bind cfgwr_seq cfgwr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .devSelected(devSelected),
  .memCeN     (memCeN),
  .memWeN     (memWeN),
  .memOeN     (memOeN),
  .memAdvN    (memAdvN),
  .memCre     (memCre),
  .memClk     (memClk),
  .memAddr    (memAddr),
  .busy       (busy),
  .done       (done),
  .selErr     (selErr)
);

// File: tb/cfgwr_seq_tb_top.sv
module cfgwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int VAL_W      = ADDR_W - 2;
  localparam int ASYNC_LEN  = 4;
  localparam int SYNC_LEN   = 3;

  typedef struct packed {
    logic              nop;
    logic              sync;
    logic [1:0]        sel;
    logic [VAL_W-1:0]  val;
    logic              expErr;
    logic [ADDR_W-1:0] expAddr;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 2'b00, 18'h15A3C, 1'b0, 20'h15A3C},  // R2 R3 refresh, async
    '{1'b0, 1'b0, 2'b10, 18'h3FFFF, 1'b0, 20'hBFFFF},  // R2 R3 bus cfg, async
    '{1'b0, 1'b1, 2'b00, 18'h00001, 1'b0, 20'h00001},  // R2 R4 refresh, sync
    '{1'b0, 1'b1, 2'b10, 18'h2A5A5, 1'b0, 20'hAA5A5},  // R2 R4 bus cfg, sync
    '{1'b1, 1'b0, 2'b10, 18'h12345, 1'b0, 20'h00000},  // R5 nop, async
    '{1'b1, 1'b1, 2'b00, 18'h0ABCD, 1'b0, 20'h00000},  // R5 nop, sync
    '{1'b0, 1'b0, 2'b01, 18'h11111, 1'b1, 20'h00000},  // R9 code 01
    '{1'b0, 1'b1, 2'b11, 18'h22222, 1'b1, 20'h00000}   // R9 code 11
  };

  // Flag order: ceN weN oeN advN cre clk busy done err
  localparam logic [8:0] IDLE_F = 9'b1111_0000_0;
  localparam logic [8:0] DONE_F = 9'b1111_0001_0;
  localparam logic [8:0] WAIT_F = 9'b1111_0010_0;
  localparam logic [8:0] ERR_F  = 9'b1111_0001_1;

  logic              clk, rstN, startCmd, isNop, syncMode, devSelected;
  logic [1:0]        regSel;
  logic [VAL_W-1:0]  regValue;
  logic              memCeN, memWeN, memOeN, memAdvN, memCre, memClk;
  logic [ADDR_W-1:0] memAddr;
  logic              busy, done, selErr;

  int totalCnt = 0;
  int failCnt  = 0;

  cfgwr_seq #(.ADDR_W(ADDR_W), .ASYNC_CYCLES(ASYNC_LEN)) dut_i (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .isNop(isNop),
    .syncMode(syncMode), .regSel(regSel), .regValue(regValue),
    .devSelected(devSelected), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memAdvN(memAdvN), .memCre(memCre), .memClk(memClk),
    .memAddr(memAddr), .busy(busy), .done(done), .selErr(selErr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic checkNow(input string tag, input logic [8:0] expF,
                          input logic [ADDR_W-1:0] expA);
    logic [8:0] actF;
    actF = {memCeN, memWeN, memOeN, memAdvN, memCre, memClk, busy, done, selErr};
    totalCnt++;
    if (actF !== expF || memAddr !== expA) begin
      failCnt++;
      $display("FAIL %s: actual pins=%b addr=%h expected pins=%b addr=%h",
               tag, actF, memAddr, expF, expA);
    end
  endtask

  function automatic int cmdLen(input vec_t v);
    return v.sync ? SYNC_LEN : ASYNC_LEN;
  endfunction

  function automatic logic [8:0] expFlags(input vec_t v, input int i);
    int len;
    len = cmdLen(v);
    if (v.expErr) return (i == 1) ? ERR_F : IDLE_F;
    if (i <= len)
      return {1'b0, v.nop, 1'b1,
              v.nop ? 1'b1 : (v.sync ? 1'b0 : (i != 1)),
              !v.nop, (v.sync && i == 2), 1'b1, 1'b0, 1'b0};
    if (i == len + 1) return DONE_F;
    return IDLE_F;
  endfunction

  function automatic logic [ADDR_W-1:0] expAddrAt(input vec_t v, input int i);
    if (!v.expErr && !v.nop && i <= cmdLen(v)) return v.expAddr;
    return '0;
  endfunction

  // Called at a falling edge; returns at the falling edge after the start edge.
  task automatic issue(input vec_t v);
    isNop    = v.nop;
    syncMode = v.sync;
    regSel   = v.sel;
    regValue = v.val;
    startCmd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startCmd = 1'b0;
  endtask

  task automatic observe(input vec_t v, input string tag, input bit glitch);
    int len;
    int last;
    len  = cmdLen(v);
    last = v.expErr ? 2 : len + 2;
    for (int i = 1; i <= last; i++) begin
      checkNow(tag, expFlags(v, i), expAddrAt(v, i));
      if (glitch) begin
        if (i == 1) begin
          // R8 R10: second start with other values mid-command
          startCmd = 1'b1;
          isNop    = 1'b0;
          syncMode = !v.sync;
          regSel   = 2'b10;
          regValue = 18'h0F0F0;
        end else if (i == 2) begin
          startCmd = 1'b0;
        end
        if (i == len + 1) begin
          // R8: start during the done cycle
          startCmd = 1'b1;
          isNop    = 1'b1;
        end
      end
      if (i < last) @(negedge clk);
    end
    startCmd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCnt++;
    totalCnt++;
    $display("FAIL R7 watchdog: actual run still active, expected completion");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    rstN        = 1'b0;
    startCmd    = 1'b0;
    isNop       = 1'b0;
    syncMode    = 1'b0;
    regSel      = 2'b00;
    regValue    = '0;
    devSelected = 1'b0;

    repeat (3) @(negedge clk);
    checkNow("R1 in reset", IDLE_F, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkNow("R1 after reset", IDLE_F, '0);
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R7 R9
    for (int k = 0; k < NVEC; k++) begin
      issue(VECS[k]);
      observe(VECS[k], $sformatf("R2-R9 vector %0d", k), 1'b0);
      @(negedge clk);
    end

    // R6: register write held while the device is selected
    devSelected = 1'b1;
    issue(VECS[3]);
    for (int k = 0; k < 3; k++) begin
      checkNow("R6 waiting while selected", WAIT_F, '0);
      if (k == 2) devSelected = 1'b0;
      @(negedge clk);
    end
    observe(VECS[3], "R6 write after deselect", 1'b0);
    @(negedge clk);

    // R6: no-operation does not wait
    devSelected = 1'b1;
    issue(VECS[5]);
    observe(VECS[5], "R6 nop while selected", 1'b0);
    devSelected = 1'b0;
    @(negedge clk);

    // R8 R10: extra starts mid-command and in done cycle ignored
    issue(VECS[0]);
    observe(VECS[0], "R8 R10 start while busy", 1'b1);
    @(negedge clk);
    checkNow("R8 idle after ignored start", IDLE_F, '0);
    @(negedge clk);

    // R7: new command accepted after done
    issue(VECS[1]);
    observe(VECS[1], "R7 accept after done", 1'b0);

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule